// File: doc/BRIEF.md
# Five-State Irregular Counter with Lockout Recovery

This block is a free-running 3-bit counter that walks a fixed, non-binary loop of five codes. The state bits are named C (bit 2), B (bit 1) and A (bit 0), and codes below are written C B A. The only inputs are the clock and a synchronous reset. Each bit is held in a toggle-style register: on every clock edge a bit flips when its toggle condition is true and holds otherwise. The toggle conditions are C: C'B' + CB, B: C'A + CB', A: C + B.

The three codes outside the loop (001, 101, 110) have defined successors, so a register bank that wakes up in any code reaches the loop within two clock edges. A status flag marks when the current code is one of the three unused ones. The parameter `PWRUP_CODE` sets the content of the register bank before the first reset, so that start-up from any code can be modelled. It has no effect once reset has been applied.

Top module: `irregular_seq_counter`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `count_q` is 3'b000 after that edge, whatever the prior code.
- R2: With `rst` low, code 000 advances to 100 at the next edge.
- R3: With `rst` low, code 100 advances to 111 at the next edge.
- R4: With `rst` low, code 111 advances to 010 at the next edge.
- R5: With `rst` low, code 010 advances to 011 at the next edge.
- R6: With `rst` low, code 011 advances to 000 at the next edge.
- R7: With `rst` low, unused code 001 advances to 111 at the next edge.
- R8: With `rst` low, unused code 110 advances to 011 at the next edge.
- R9: With `rst` low, unused code 101 advances to 110 at the next edge, and so reaches the loop at the second edge.
- R10: `off_cycle` is 1 exactly when `count_q` is 001, 101 or 110, and 0 for the five loop codes. It depends only on the current code.
- R11: Before the first rising edge, `count_q` equals `PWRUP_CODE`. From any start code and with `rst` low, `count_q` is a loop code after at most two edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, forces code 000 |
| count_q | output | 3 | Current code; bit 2 = C, bit 1 = B, bit 0 = A |
| off_cycle | output | 1 | High while the code is one of the three unused ones |

## Verification
Each code, and each reset, takes effect at the first rising edge after the stimulus. `off_cycle` follows the code it describes in the same cycle, with no extra register delay. The bench drives `rst` and samples both outputs at the falling edge. Its model steps the expected code once per rising edge, so every comparison sees the result of exactly one edge.

The bench runs eight extra instances, one for each power-up code. They are checked before the first edge and then edge by edge until reset. This covers every unused code and the recovery paths in R7 to R9 and R11.

// File: rtl/irregular_seq_pkg.sv
package irregular_seq_pkg;
  localparam int CODE_W = 3;
  localparam int BIT_C  = 2;
  localparam int BIT_B  = 1;
  localparam int BIT_A  = 0;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t LOOP_S0 = 3'b000;
  localparam code_t LOOP_S1 = 3'b100;
  localparam code_t LOOP_S2 = 3'b111;
  localparam code_t LOOP_S3 = 3'b010;
  localparam code_t LOOP_S4 = 3'b011;
  localparam code_t SPARE_X = 3'b001;
  localparam code_t SPARE_Y = 3'b101;
  localparam code_t SPARE_Z = 3'b110;
  localparam code_t RESET_CODE = LOOP_S0;
endpackage

// File: rtl/seq_toggle_logic.sv
module seq_toggle_logic
  import irregular_seq_pkg::*;
(
  input  code_t cur,
  output code_t tgl
);
  logic c, b, a;
  assign c = cur[BIT_C];
  assign b = cur[BIT_B];
  assign a = cur[BIT_A];

  // Per-bit flip conditions for the five-state loop
  always_comb begin
    tgl         = '0;
    tgl[BIT_C]  = (~c & ~b) | (c & b);
    tgl[BIT_B]  = (~c & a) | (c & ~b);
    tgl[BIT_A]  = c | b;
  end
endmodule

// File: rtl/seq_toggle_bank.sv
module seq_toggle_bank
  import irregular_seq_pkg::*;
#(
  parameter code_t PWRUP_CODE = RESET_CODE
) (
  input  logic  clk,
  input  logic  rst,
  input  code_t tgl,
  output code_t q
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    logic bit_q = PWRUP_CODE[i];
    always_ff @(posedge clk) begin
      if (rst)         bit_q <= RESET_CODE[i];
      else if (tgl[i]) bit_q <= ~bit_q;
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/seq_off_detect.sv
module seq_off_detect
  import irregular_seq_pkg::*;
(
  input  code_t cur,
  output logic  off
);
  always_comb begin
    unique case (cur)
      SPARE_X, SPARE_Y, SPARE_Z: off = 1'b1;
      default:                   off = 1'b0;
    endcase
  end
endmodule

// File: rtl/irregular_seq_counter.sv
module irregular_seq_counter
  import irregular_seq_pkg::*;
#(
  parameter code_t PWRUP_CODE = RESET_CODE
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] count_q,
  output logic       off_cycle
);
  code_t state, flips;

  seq_toggle_logic u_tlogic (
    .cur (state),
    .tgl (flips)
  );

  seq_toggle_bank #(.PWRUP_CODE(PWRUP_CODE)) u_bank (
    .clk (clk),
    .rst (rst),
    .tgl (flips),
    .q   (state)
  );

  seq_off_detect u_odet (
    .cur (state),
    .off (off_cycle)
  );

  assign count_q = state;

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> count_q == RESET_CODE);
  assert_step_s0_R2: assert property (@(posedge clk) disable iff (rst)
    count_q == LOOP_S0 |=> count_q == LOOP_S1);
  assert_step_s1_R3: assert property (@(posedge clk) disable iff (rst)
    count_q == LOOP_S1 |=> count_q == LOOP_S2);
  assert_step_s2_R4: assert property (@(posedge clk) disable iff (rst)
    count_q == LOOP_S2 |=> count_q == LOOP_S3);
  assert_step_s3_R5: assert property (@(posedge clk) disable iff (rst)
    count_q == LOOP_S3 |=> count_q == LOOP_S4);
  assert_step_s4_R6: assert property (@(posedge clk) disable iff (rst)
    count_q == LOOP_S4 |=> count_q == LOOP_S0);
  assert_spare_x_R7: assert property (@(posedge clk) disable iff (rst)
    count_q == SPARE_X |=> count_q == LOOP_S2);
  assert_spare_z_R8: assert property (@(posedge clk) disable iff (rst)
    count_q == SPARE_Z |=> count_q == LOOP_S4);
  assert_spare_y_R9: assert property (@(posedge clk) disable iff (rst)
    count_q == SPARE_Y |=> count_q == SPARE_Z);
  assert_flag_loop_R10: assert property (@(posedge clk)
    (count_q == LOOP_S0 || count_q == LOOP_S2) |-> !off_cycle);
  assert_recover_R11: assert property (@(posedge clk) disable iff (rst)
    off_cycle |=> (!off_cycle || count_q == SPARE_Z));
endmodule

// File: tb/irregular_seq_counter_tb.sv
module irregular_seq_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CYC = 400;

  logic clk = 1'b0;
  logic rst = 1'b0;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0] cnt_main;
  logic       off_main;
  irregular_seq_counter u_dut (
    .clk(clk), .rst(rst), .count_q(cnt_main), .off_cycle(off_main)
  );

  logic [2:0] cnt_pu [8];
  logic       off_pu [8];
  for (genvar k = 0; k < 8; k++) begin : g_pu
    irregular_seq_counter #(.PWRUP_CODE(3'(k))) u_pu (
      .clk(clk), .rst(rst), .count_q(cnt_pu[k]), .off_cycle(off_pu[k])
    );
  end

  function automatic logic [2:0] nxt(input logic [2:0] s);
    case (s)
      3'b000: nxt = 3'b100;
      3'b100: nxt = 3'b111;
      3'b111: nxt = 3'b010;
      3'b010: nxt = 3'b011;
      3'b011: nxt = 3'b000;
      3'b001: nxt = 3'b111;
      3'b110: nxt = 3'b011;
      default: nxt = 3'b110;
    endcase
  endfunction

  function automatic logic spare(input logic [2:0] s);
    return (s == 3'b001) || (s == 3'b101) || (s == 3'b110);
  endfunction

  function automatic string tag(input logic [2:0] prev, input logic r);
    if (r) return "R1";
    case (prev)
      3'b000: return "R2";
      3'b100: return "R3";
      3'b111: return "R4";
      3'b010: return "R5";
      3'b011: return "R6";
      3'b001: return "R7";
      3'b110: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk_code(input string rq, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s count_q actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic chk_flag(input logic act, input logic [2:0] code);
    n_chk++;
    if (act !== spare(code)) begin
      n_bad++;
      $display("FAIL R10 off_cycle at code %b actual=%b expected=%b", code, act, spare(code));
    end
  endtask

  logic [2:0] exp_main, exp_pu [8], prev_main, prev_pu [8];
  logic       last_rst;
  int         steps_since_start;

  initial begin
    void'($urandom(32'd1234));
    exp_main = 3'b000;
    for (int k = 0; k < 8; k++) exp_pu[k] = 3'(k);
    last_rst = 1'b0;
    #1;
    // R11: power-up contents before first edge
    chk_code("R11", cnt_main, exp_main);
    chk_flag(off_main, exp_main);
    for (int k = 0; k < 8; k++) begin
      chk_code("R11", cnt_pu[k], exp_pu[k]);
      chk_flag(off_pu[k], exp_pu[k]);
    end
    steps_since_start = 0;
    for (int cyc = 0; cyc < N_CYC; cyc++) begin
      prev_main = exp_main;
      for (int k = 0; k < 8; k++) prev_pu[k] = exp_pu[k];
      // drive rst for the coming edge: none for the first 6 edges, then random
      if (cyc < 6) rst = 1'b0;
      else if (cyc == 6 || cyc == 7) rst = 1'b1;
      else rst = (($urandom % 16) == 0);
      last_rst = rst;
      exp_main = rst ? 3'b000 : nxt(exp_main);
      for (int k = 0; k < 8; k++) exp_pu[k] = rst ? 3'b000 : nxt(exp_pu[k]);
      @(negedge clk);
      steps_since_start++;
      chk_code(tag(prev_main, last_rst), cnt_main, exp_main);
      chk_flag(off_main, exp_main);
      for (int k = 0; k < 8; k++) begin
        chk_code(tag(prev_pu[k], last_rst), cnt_pu[k], exp_pu[k]);
        chk_flag(off_pu[k], exp_pu[k]);
        if (steps_since_start == 2) begin
          // R11: every start code lies in the loop after two edges
          n_chk++;
          if (spare(cnt_pu[k])) begin
            n_bad++;
            $display("FAIL R11 start %0d after two edges actual=%b expected=loop code", k, cnt_pu[k]);
          end
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule